// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Sender

This block is the device-side engine that sources one data-in burst toward a host over a double-edge strobed link. On a local start request it raises its request line. It waits for the host acknowledge, then holds off a mode-dependent time before it drives the strobe and data lines. It then pulls 16-bit words from a FIFO-style source and sends one word on every strobe transition, rising and falling alike.

Every bus timing rule is converted at elaboration time from nanoseconds into whole clock cycles, rounding up, from the clock period parameter. One lookup entry is built per transfer mode. The mode is captured when the burst starts. The host may pause the stream by lowering its ready input and may end it with its stop input. Once the host then releases the acknowledge, the engine pulses a done output and goes back to idle.

Top module: `udma_din_sender`

## Requirements
- R1: During reset and right after it, dev_req, dev_drive, word_take and burst_done are 0, dev_strobe is 1 and dev_data is 0.
- R2: dev_req rises on the clock edge after burst_req is sampled high in idle. dev_drive rises, with dev_strobe at 1, no earlier than ceil(20 ns / period) clock edges (4 at 5 ns) after host_ack is first sampled high. The edge is the first one at which that count has elapsed.
- R3: Any two successive strobe transitions are at least ceil(Tc / period) edges apart, with Tc = 114, 75 or 55 ns for mode 0, 1 or 2 (23, 15 or 11 cycles at 5 ns).
- R4: Two transitions of the same direction are at least ceil(T2 / period) edges apart, with T2 = 235, 156 or 117 ns (47, 32 or 24 cycles at 5 ns).
- R5: dev_data is stable for at least ceil(Ts / period) edges before each strobe transition, with Ts = 70, 48 or 34 ns (14, 10 or 7 cycles at 5 ns).
- R6: dev_data does not change until ceil(6 ns / period) edges (2 at 5 ns) after a strobe transition. Each transition, rising or falling, carries exactly one word, and the first one after drive-on is falling. Every transition happens at the first edge at which all timing limits, ready and data allow it.
- R7: No strobe transition happens at an edge where host_ready is sampled 0. Transitions resume once host_ready is 1 again.
- R8: While the word source is empty, the strobe keeps its level. Sending resumes when a word becomes available.
- R9: After host_stop is sampled high, no further strobe transition is sent. Once the data hold time of the last transition has elapsed, dev_drive and dev_req fall together. When host_ack is then sampled low, burst_done is high for exactly one cycle and the engine is idle.
- R10: mode_sel is captured when the burst starts. The value 3 behaves like mode 2. The first transition comes 1 + ceil(Ts / period) edges after dev_drive rises when a word and host_ready are already present.
- R11: word_take is high only while word_valid is high, at most once per transmitted word, and only after the hold time of the previous transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Transfer mode 0..2 (3 acts as 2), captured at burst start |
| burst_req | input | 1 | Local request to start a burst |
| word_valid | input | 1 | Word source holds a word |
| word_data | input | 16 | Word at the head of the source |
| word_take | output | 1 | Pops the head word this cycle |
| dev_req | output | 1 | Device request to the host |
| host_ack | input | 1 | Host acknowledge, active high |
| host_stop | input | 1 | Host stop request |
| host_ready | input | 1 | Host ready; low asks for a pause |
| dev_strobe | output | 1 | Data strobe level |
| dev_data | output | 16 | Data word on the bus |
| dev_drive | output | 1 | Output enable for strobe and data |
| burst_done | output | 1 | One-cycle pulse when the burst has closed |

## Verification
The bound checker watches the timing on every cycle. It checks the spacing of successive and same-direction strobe transitions, data setup before and hold after each transition, the delay from acknowledge to drive-on, the absence of transitions during a host pause, and the line state at the done pulse. Exact cycle placement cannot be judged by fixed rules. That covers the falling first edge, the earliest-possible firing, the word count per burst, the mode-3 fallback and the hold-off while the source is empty. The bench shows these through a behavioural model compared every clock, across scenarios for pause, empty source, early stop and each mode.

// File: rtl/udma_pkg.sv
// Shared types and the ns-to-cycle conversion for the data-in burst sender.
// Assumes all timing counts fit in TIM_W bits for the chosen clock period.
package udma_pkg;

    localparam int TIM_W  = 12;
    localparam int N_AGE  = 4;
    localparam int AGE_EDGE = 0;
    localparam int AGE_PREV = 1;
    localparam int AGE_DATA = 2;
    localparam int AGE_AUX  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_AWAIT, ST_LOAD, ST_SEND, ST_REL
    } st_e;

    // Per-mode limits, already in clock cycles.
    typedef struct packed {
        logic [TIM_W-1:0] cyc;   // min gap between any two transitions
        logic [TIM_W-1:0] t2;    // min gap between same-direction transitions
        logic [TIM_W-1:0] dvs;   // data stable before a transition
        logic [TIM_W-1:0] dvh;   // data held after a transition
        logic [TIM_W-1:0] zi;    // wait after acknowledge before driving
    } tim_t;

    // Round a ns figure up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    // Limits for one mode; any code above 2 maps to the fastest mode.
    function automatic tim_t build_timing(input int mode, input int clk_ps);
        tim_t t;
        int c_ns, t2_ns, s_ns;
        case (mode)
            0:       begin c_ns = 114; t2_ns = 235; s_ns = 70; end
            1:       begin c_ns = 75;  t2_ns = 156; s_ns = 48; end
            default: begin c_ns = 55;  t2_ns = 117; s_ns = 34; end
        endcase
        t.cyc = TIM_W'(ns_to_cyc(c_ns, clk_ps));
        t.t2  = TIM_W'(ns_to_cyc(t2_ns, clk_ps));
        t.dvs = TIM_W'(ns_to_cyc(s_ns, clk_ps));
        t.dvh = TIM_W'(ns_to_cyc(6, clk_ps));
        t.zi  = TIM_W'(ns_to_cyc(20, clk_ps));
        return t;
    endfunction

    // Pause cut-off per mode, used only for checking.
    function automatic int rfs_cycles(input int mode, input int clk_ps);
        case (mode)
            0:       return ns_to_cyc(75, clk_ps);
            1:       return ns_to_cyc(60, clk_ps);
            default: return ns_to_cyc(50, clk_ps);
        endcase
    endfunction

endpackage

// File: rtl/udma_age_ctr.sv
// Saturating age counter: counts clocks since it was last loaded.
// Assumes the all-ones value stands for "long ago".
module udma_age_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] age
);

    // Load on request, otherwise count up and stick at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '1;
        else if (ld)
            age <= ld_val;
        else if (age != '1)
            age <= age + 1'b1;
    end

endmodule

// File: rtl/udma_mode_table.sv
// Captures the transfer mode at burst start and serves its cycle limits.
// Assumes mode_in is stable in the cycle capture is high.
module udma_mode_table
    import udma_pkg::*;
#(
    parameter int CLK_PS = 5000,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [MODE_W-1:0] mode_in,
    output tim_t              tim,
    output logic [TIM_W-1:0]  rfs_lim
);

    localparam int N_CODES = 1 << MODE_W;

    tim_t             tab     [N_CODES];
    logic [TIM_W-1:0] rfs_tab [N_CODES];
    logic [MODE_W-1:0] mode_q;

    // One constant entry per mode code.
    for (genvar m = 0; m < N_CODES; m++) begin : g_mode
        localparam tim_t T = build_timing(m, CLK_PS);
        localparam int   R = rfs_cycles(m, CLK_PS);
        assign tab[m]     = T;
        assign rfs_tab[m] = TIM_W'(R);
    end

    // Hold the mode for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (capture)
            mode_q <= mode_in;
    end

    assign tim     = tab[mode_q];
    assign rfs_lim = rfs_tab[mode_q];

endmodule

// File: rtl/udma_burst_ctrl.sv
// Burst sequencer: request/acknowledge handshake, word loading, strobe
// transitions gated by the age counters, pause, stop and close-out.
// Assumes host inputs are synchronous to clk.
module udma_burst_ctrl
    import udma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tim_t                        tim,
    input  logic                        burst_req,
    input  logic                        word_valid,
    input  logic [DATA_W-1:0]           word_data,
    output logic                        word_take,
    input  logic                        host_ack,
    input  logic                        host_stop,
    input  logic                        host_ready,
    input  logic [N_AGE-1:0][TIM_W-1:0] ages,
    output logic [N_AGE-1:0]            age_ld,
    output logic [N_AGE-1:0][TIM_W-1:0] age_ld_val,
    output logic                        mode_capture,
    output logic                        dev_req,
    output logic                        dev_drive,
    output logic                        dev_strobe,
    output logic [DATA_W-1:0]           dev_data,
    output logic                        burst_done
);

    st_e st, st_nx;
    logic [TIM_W-1:0] a_edge, a_prev, a_data, a_aux;
    logic hold_ok, ack_seen, go_drive, stop_now, take, fire, closing;

    assign a_edge = ages[AGE_EDGE];
    assign a_prev = ages[AGE_PREV];
    assign a_data = ages[AGE_DATA];
    assign a_aux  = ages[AGE_AUX];

    assign hold_ok  = a_edge >= tim.dvh;
    assign ack_seen = (st == ST_REQ) && host_ack;
    assign go_drive = (st == ST_AWAIT) && (a_aux >= tim.zi);
    assign stop_now = host_stop && hold_ok && ((st == ST_LOAD) || (st == ST_SEND));
    assign take     = (st == ST_LOAD) && hold_ok && !host_stop && word_valid;
    assign fire     = (st == ST_SEND) && !host_stop && host_ready &&
                      (a_data >= tim.dvs) && (a_edge >= tim.cyc) && (a_prev >= tim.t2);
    assign closing  = (st == ST_REL) && !host_ack;

    assign word_take    = take;
    assign mode_capture = (st == ST_IDLE) && burst_req;

    // Next-state selection.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (burst_req) st_nx = ST_REQ;
            ST_REQ:   if (host_ack) st_nx = ST_AWAIT;
            ST_AWAIT: if (go_drive) st_nx = ST_LOAD;
            ST_LOAD:  if (stop_now) st_nx = ST_REL;
                      else if (take) st_nx = ST_SEND;
            ST_SEND:  if (stop_now) st_nx = ST_REL;
                      else if (fire) st_nx = ST_LOAD;
            ST_REL:   if (closing) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Restart or preset the age counters on timing events.
    always_comb begin
        age_ld     = '0;
        age_ld_val = '0;
        age_ld[AGE_AUX]      = ack_seen;
        age_ld_val[AGE_AUX]  = TIM_W'(1);
        age_ld[AGE_DATA]     = take;
        age_ld_val[AGE_DATA] = TIM_W'(1);
        age_ld[AGE_EDGE]     = fire || go_drive;
        age_ld_val[AGE_EDGE] = go_drive ? '1 : TIM_W'(1);
        age_ld[AGE_PREV]     = fire || go_drive;
        if (go_drive || (a_edge == '1))
            age_ld_val[AGE_PREV] = '1;
        else
            age_ld_val[AGE_PREV] = a_edge + 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // Registered bus-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_req    <= 1'b0;
            dev_drive  <= 1'b0;
            dev_strobe <= 1'b1;
            dev_data   <= '0;
            burst_done <= 1'b0;
        end else begin
            burst_done <= closing;
            if (mode_capture)
                dev_req <= 1'b1;
            else if (stop_now)
                dev_req <= 1'b0;
            if (go_drive) begin
                dev_drive  <= 1'b1;
                dev_strobe <= 1'b1;
            end else if (stop_now) begin
                dev_drive <= 1'b0;
            end else if (fire) begin
                dev_strobe <= ~dev_strobe;
            end
            if (take)
                dev_data <= word_data;
        end
    end

endmodule

// File: rtl/udma_din_sender.sv
// Top of the data-in burst sender: mode table, four age counters and the
// burst sequencer. Assumes CLK_PS keeps every limit below 2**TIM_W cycles.
module udma_din_sender
    import udma_pkg::*;
#(
    parameter int CLK_PS = 5000,
    parameter int DATA_W = 16,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              burst_req,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    output logic              word_take,
    output logic              dev_req,
    input  logic              host_ack,
    input  logic              host_stop,
    input  logic              host_ready,
    output logic              dev_strobe,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_drive,
    output logic              burst_done
);

    tim_t                        tim;
    logic [TIM_W-1:0]            rfs_lim;
    logic                        mode_capture;
    logic [N_AGE-1:0]            age_ld;
    logic [N_AGE-1:0][TIM_W-1:0] age_ld_val;
    logic [N_AGE-1:0][TIM_W-1:0] ages;

    udma_mode_table #(.CLK_PS(CLK_PS), .MODE_W(MODE_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .capture(mode_capture),
        .mode_in(mode_sel), .tim(tim), .rfs_lim(rfs_lim)
    );

    // One age counter per timing reference point.
    for (genvar i = 0; i < N_AGE; i++) begin : g_age
        udma_age_ctr #(.W(TIM_W)) u_age (
            .clk(clk), .rst_n(rst_n), .ld(age_ld[i]),
            .ld_val(age_ld_val[i]), .age(ages[i])
        );
    end

    udma_burst_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tim(tim),
        .burst_req(burst_req), .word_valid(word_valid),
        .word_data(word_data), .word_take(word_take),
        .host_ack(host_ack), .host_stop(host_stop), .host_ready(host_ready),
        .ages(ages), .age_ld(age_ld), .age_ld_val(age_ld_val),
        .mode_capture(mode_capture), .dev_req(dev_req),
        .dev_drive(dev_drive), .dev_strobe(dev_strobe),
        .dev_data(dev_data), .burst_done(burst_done)
    );

endmodule

// File: rtl/udma_din_sender_chk.sv
// Timing checker bound to udma_din_sender. It keeps its own ages, measured
// from transitions it sees on the ports, and compares them to the limits.
module udma_din_sender_chk
    import udma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_ready,
    input logic              word_valid,
    input logic              word_take,
    input logic              dev_req,
    input logic              dev_drive,
    input logic              dev_strobe,
    input logic [DATA_W-1:0] dev_data,
    input logic              burst_done,
    input tim_t              tim,
    input logic [TIM_W-1:0]  rfs_lim
);

    localparam int CW = 16;
    localparam logic [CW-1:0] SAT = '1;

    logic              strobe_d, drive_d;
    logic [DATA_W-1:0] data_d;
    logic [CW-1:0]     c_edge, c_prev, c_data, c_ack, c_rdylow;
    logic              edge_now, data_chg, drive_on;

    assign edge_now = drive_d && dev_drive && (dev_strobe != strobe_d);
    assign data_chg = drive_d && dev_drive && (dev_data != data_d);
    assign drive_on = dev_drive && !drive_d;

    // Delayed port copies and checker-side age counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d <= 1'b1; drive_d <= 1'b0; data_d <= '0;
            c_edge <= SAT; c_prev <= SAT; c_data <= SAT;
            c_ack <= '0; c_rdylow <= '0;
        end else begin
            strobe_d <= dev_strobe; drive_d <= dev_drive; data_d <= dev_data;
            if (drive_on) begin
                c_edge <= SAT; c_prev <= SAT;
            end else if (edge_now) begin
                c_edge <= 1;
                c_prev <= (c_edge == SAT) ? SAT : c_edge + 1'b1;
            end else begin
                if (c_edge != SAT) c_edge <= c_edge + 1'b1;
                if (c_prev != SAT) c_prev <= c_prev + 1'b1;
            end
            if (data_chg) c_data <= 1;
            else if (c_data != SAT) c_data <= c_data + 1'b1;
            c_ack    <= host_ack ? ((c_ack == SAT) ? SAT : c_ack + 1'b1) : '0;
            c_rdylow <= host_ready ? '0 : ((c_rdylow == SAT) ? SAT : c_rdylow + 1'b1);
        end
    end

    a_r2_drive_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |-> (c_ack >= CW'(tim.zi)));
    a_r3_edge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |-> (c_edge >= CW'(tim.cyc)));
    a_r4_same_dir_gap: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |-> (c_prev >= CW'(tim.t2)));
    a_r5_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |-> (c_data >= CW'(tim.dvs)));
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        data_chg |-> (c_edge >= CW'(tim.dvh)));
    a_r7_pause_cutoff: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |-> (c_rdylow < CW'(rfs_lim)));
    a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (!dev_drive && !dev_req));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);
    a_r11_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |-> word_valid);

endmodule

bind udma_din_sender udma_din_sender_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_udma_din_sender.sv
`timescale 1ns/100ps
module sim_udma_din_sender;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic burst_req = 1'b0, word_valid = 1'b0, host_ack = 1'b0;
    logic host_stop = 1'b0, host_ready = 1'b0;
    logic [15:0] word_data = '0;
    logic word_take, dev_req, dev_strobe, dev_drive, burst_done;
    logic [15:0] dev_data;

    int checks = 0, fails = 0, wd = 0;
    int cyc = 0;
    logic [15:0] wq[$];
    logic gate = 1'b1;

    // behavioural reference state
    int m_st = 0, m_mode = 0, m_le = -100000, m_pe = -100000, m_lc = -100000, m_ac = 0;
    bit m_req = 0, m_drv = 0, m_stb = 1, m_done = 0, m_took = 0;
    logic [15:0] m_dat = '0;

    // port-side observations
    int dut_edges = 0, done_cnt = 0, ncyc = 0, rise_c = -1, first_c = -1;
    logic p_stb = 1'b1, p_drv = 1'b0;

    always #2.5 clk = ~clk;

    udma_din_sender u0 (.*);

    function automatic int ceil5(input int ns);
        return (ns * 1000 + 4999) / 5000;
    endfunction
    function automatic int lim_c(input int m);
        return ceil5(m == 0 ? 114 : m == 1 ? 75 : 55);
    endfunction
    function automatic int lim_t2(input int m);
        return ceil5(m == 0 ? 235 : m == 1 ? 156 : 117);
    endfunction
    function automatic int lim_s(input int m);
        return ceil5(m == 0 ? 70 : m == 1 ? 48 : 34);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model: steps at every clock edge from the sampled inputs.
    always @(posedge clk) begin
        m_took = 0;
        if (!rst_n) begin
            m_st = 0; m_req = 0; m_drv = 0; m_stb = 1; m_dat = '0; m_done = 0;
            m_le = -100000; m_pe = -100000; m_lc = -100000;
        end else begin
            m_done = 0;
            case (m_st)
                0: if (burst_req) begin
                       m_mode = (mode_sel == 2'd3) ? 2 : int'(mode_sel);
                       m_req = 1; m_st = 1;
                   end
                1: if (host_ack) begin m_ac = cyc; m_st = 2; end
                2: if (cyc - m_ac >= ceil5(20)) begin
                       m_drv = 1; m_stb = 1; m_le = -100000; m_pe = -100000; m_st = 3;
                   end
                3: if (cyc - m_le >= ceil5(6)) begin
                       if (host_stop) begin m_drv = 0; m_req = 0; m_st = 5; end
                       else if (word_valid) begin
                           m_dat = word_data; m_lc = cyc; m_took = 1; m_st = 4;
                       end
                   end
                4: if (host_stop) begin m_drv = 0; m_req = 0; m_st = 5; end
                   else if (host_ready && cyc - m_lc >= lim_s(m_mode) &&
                            cyc - m_le >= lim_c(m_mode) && cyc - m_pe >= lim_t2(m_mode)) begin
                       m_stb = !m_stb; m_pe = m_le; m_le = cyc; m_st = 3;
                   end
                5: if (!host_ack) begin m_done = 1; m_st = 0; end
                default: m_st = 0;
            endcase
        end
        cyc++;
    end

    // Word source: pop on the model's take, then present the next head word.
    always @(posedge clk) begin
        #1;
        if (m_took && wq.size() > 0) void'(wq.pop_front());
        word_valid = gate && (wq.size() > 0);
        word_data  = (wq.size() > 0) ? wq[0] : 16'h0;
    end

    // Mid-cycle comparison against the model and port observation.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_take;
            exp_take = (m_st == 3) && word_valid && !host_stop && (cyc - m_le >= ceil5(6));
            chk("R2 dev_req", dev_req, m_req);
            chk("R2 dev_drive", dev_drive, m_drv);
            chk("R3 dev_strobe", dev_strobe, m_stb);
            chk("R6 dev_data", dev_data, m_dat);
            chk("R9 burst_done", burst_done, m_done);
            chk("R11 word_take", word_take, exp_take);
            if (dev_drive && p_drv && dev_strobe != p_stb) begin
                dut_edges++;
                if (first_c < 0) first_c = ncyc;
            end
            if (dev_drive && !p_drv) rise_c = ncyc;
            if (burst_done) done_cnt++;
        end
        p_stb = dev_strobe; p_drv = dev_drive; ncyc++;
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #0.5; end
    endtask

    task automatic push(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) wq.push_back(base + 16'(i));
    endtask

    task automatic start(input logic [1:0] m);
        dut_edges = 0; done_cnt = 0; rise_c = -1; first_c = -1;
        mode_sel = m; burst_req = 1'b1; step(1); burst_req = 1'b0;
        step(3); host_ack = 1'b1; host_ready = 1'b1;
    endtask

    task automatic wait_edges(input int n);
        while (dut_edges < n) step(1);
    endtask

    task automatic finish_burst;
        host_stop = 1'b1;
        while (dev_drive) step(1);
        step(2); host_ack = 1'b0; host_stop = 1'b0; host_ready = 1'b0;
        step(3);
        chk("R9 done pulse count", done_cnt, 1);
        chk("R9 req released", dev_req, 0);
    endtask

    initial begin
        int snap;
        step(3);
        chk("R1 reset req", dev_req, 0);
        chk("R1 reset drive", dev_drive, 0);
        chk("R1 reset strobe", dev_strobe, 1);
        chk("R1 reset data", dev_data, 0);
        chk("R1 reset done", burst_done, 0);
        chk("R1 reset take", word_take, 0);
        rst_n = 1'b1; step(2);

        // Mode 0, steady stream of six words.
        push(6, 16'h1000); start(2'd0); wait_edges(6); step(2);
        chk("R6 words per burst mode0", dut_edges, 6);
        chk("R11 all words taken", wq.size(), 0);
        chk("R10 first edge latency mode0", first_c - rise_c, 1 + lim_s(0));
        finish_burst();

        // Mode 1 with a host pause after three words.
        push(8, 16'h2000); start(2'd1); wait_edges(3);
        host_ready = 1'b0; step(1); snap = dut_edges; step(40);
        chk("R7 no edge while paused", dut_edges, snap);
        host_ready = 1'b1; wait_edges(8); step(2);
        chk("R7 resume after pause", dut_edges, 8);
        finish_burst();

        // Mode 2 with the source running dry mid-burst.
        push(3, 16'h3000); start(2'd2); wait_edges(3);
        step(1); snap = dut_edges; step(30);
        chk("R8 strobe held while empty", dut_edges, snap);
        push(3, 16'h3100); wait_edges(6); step(2);
        chk("R8 resume after refill", dut_edges, 6);
        chk("R10 first edge latency mode2", first_c - rise_c, 1 + lim_s(2));
        finish_burst();

        // Code 3 falls back to mode 2 timing.
        push(2, 16'h4000); start(2'd3); wait_edges(2); step(2);
        chk("R10 mode3 latency", first_c - rise_c, 1 + lim_s(2));
        finish_burst();

        // Early stop after two words.
        push(10, 16'h5000); start(2'd0); wait_edges(2);
        host_stop = 1'b1; step(60);
        chk("R9 no edge after stop", dut_edges, 2);
        chk("R9 drive released", dev_drive, 0);
        finish_burst();
        wq.delete(); step(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule